// File: doc/BRIEF.md
# Byte-Wide SPI Peripheral with Master-Loss Fallback

This block is a single-byte serial peripheral interface engine that a processor drives through a small three-register bus. It works either as a bus master, generating the serial clock from the system clock through a two-bit rate choice, or as a slave that follows an external serial clock. The serial clock idles low. The most significant bit goes first. Outgoing bits change on the falling edge of the serial clock and incoming bits are sampled on the rising edge.

While it runs as a master, the block watches its slave-select pin. If another master pulls that pin low and slave select is not being ignored, the block gives up the master role at once. It clears its own master bit, turns its clock and data-out pins into inputs, starts driving the slave data-out pin, and signals completion so that software learns of the change. It remains a slave until software sets the master bit again. The transmit side has one buffer only: a write that arrives while a byte is in flight is dropped and flagged. Each received byte is copied into a separate read register, which the next completed byte overwrites.

Register map, selected by `bus_addr`:
- Address 0 is the control register: bit 0 enable, bit 1 master, bit 2 ignore slave select, bit 3 interrupt enable, bits 5:4 rate.
- Address 1 is the status register: bit 7 transfer complete, bit 6 write collision. Both bits clear when 1 is written to them.
- Address 2 is the data register: a write loads the transmit byte, and a read returns the last received byte.

Top module: `spi_node`

## Requirements
- R1: After reset the control, status and data registers read 0x00, `irq` is low and all three pin enables (`sck_oe`, `mosi_oe`, `miso_oe`) are low.
- R2: In master mode (control bit 0 = 1, bit 1 = 1, and either bit 2 = 1 or `ss_n` high), writing the data register sends that byte on `mosi_out` MSB first, with `sck_out` idle low and data valid before each rising edge. It captures 8 bits from `miso_in` on the rising edges. Status bit 7 then sets, and `irq` follows status bit 7 whenever control bit 3 is 1.
- R3: The `sck_out` period is 4, 16, 64 or 128 system clocks for a rate field (control bits 5:4) of 00, 01, 10 or 11. `sck_out` only toggles on an internal divider tick.
- R4: With master and enable set, slave select not ignored, and `ss_n` low, the block clears control bit 1 and sets status bit 7. It then drops `sck_oe` and `mosi_oe` and raises `miso_oe`.
- R5: After such a fallback the block stays a slave when `ss_n` returns high. It becomes a master again only when software writes control bit 1 to 1.
- R6: With control bit 2 = 1, `ss_n` has no effect: a master stays a master and still transfers with `ss_n` low.
- R7: Writing the data register while a byte is being shifted, in either mode, sets status bit 6. The written byte is discarded and the byte in progress completes unchanged.
- R8: Writing 1 to status bit 7 or bit 6 clears that bit. Writing 0 leaves it unchanged.
- R9: Each completed byte is copied into the read register. A byte that is not read before the next one completes is overwritten by it.
- R10: In slave mode (control bit 0 = 1, bit 1 = 0) the block is selected when `ss_n` is low or control bit 2 is 1. `sck_in`, `mosi_in` and `ss_n` pass through two-flop synchronizers. The block shifts out its loaded byte on `miso_out` MSB first and receives `mosi_in` on rising edges. `miso_oe` is high only while selected.
- R11: `sck_oe` and `mosi_oe` are high only in master mode and are never high together with `miso_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Transfer-complete interrupt, gated by control bit 3 |
| ss_n | input | 1 | Slave-select pin, active low |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| mosi_in | input | 1 | Serial data in, slave mode |
| mosi_out | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for the master-out pin |
| miso_in | input | 1 | Serial data in, master mode |
| miso_out | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for the slave-out pin |

## Verification
Four rules are checked every cycle by properties:
- The cycle after a mode fault always shows the master bit cleared and the completion flag set.
- A data write during a busy transfer always leaves the collision flag set.
- The read register never changes without the completion flag.
- The master clock only toggles on a divider tick, and the master pin enables never overlap with the slave data-out enable.

The scenarios show what the properties cannot:
- The exact clock period at each rate.
- MSB-first byte content on both serial lines against a bench slave and a bench master.
- That a fallback persists after the slave-select pin is released.
- That a collided byte never appears on the wire.
- That an unread byte is lost to the next one.

// File: rtl/spi_node_pkg.sv
package spi_node_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_MST  = 1;
    localparam int CTL_SSIG = 2;
    localparam int CTL_IE   = 3;
    localparam int CTL_RATE = 4;

    localparam int ST_WCOL  = 6;
    localparam int ST_DONE  = 7;

    localparam int unsigned MAX_HALF = 64;

    // Half of the serial clock period, in system clocks
    function automatic int unsigned half_period(input logic [1:0] rate);
        case (rate)
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 32;
            default: return MAX_HALF;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[i]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign dout[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
    import spi_node_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        limit    = CNT_W'(half_period(rate) - 1);
        at_limit = (cnt_q == limit);
        tick     = run && at_limit;
        if (!run || at_limit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_node.sv
module spi_node
    import spi_node_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              ss_n,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam int DIV_W = $clog2(MAX_HALF);
    localparam int MSB   = DATA_W - 1;

    typedef struct packed {
        logic              en;
        logic              mst;
        logic              ssig;
        logic              ie;
        logic [1:0]        rate;
        logic              done;
        logic              wcol;
        logic              busy;
        logic [CNT_W-1:0]  bits;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] rxbuf;
        logic              samp;
        logic              sck;
        logic              sck_prev;
    } node_st_t;

    node_st_t st_d, st_q;

    logic [2:0] sync_out;
    logic       ss_s, sck_s, mosi_s;
    logic       div_tick;
    logic       master_mode, slave_sel, fault_det;
    logic       wr_ctrl, wr_stat, wr_data;
    logic       sck_rise, sck_fall;

    spi_pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n, sck_in, mosi_in}),
        .dout (sync_out)
    );

    assign ss_s   = sync_out[2];
    assign sck_s  = sync_out[1];
    assign mosi_s = sync_out[0];

    spi_rate_div #(
        .CNT_W(DIV_W)
    ) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (master_mode && st_q.busy),
        .rate (st_q.rate),
        .tick (div_tick)
    );

    always_comb begin
        master_mode = st_q.en && st_q.mst && (st_q.ssig || ss_s);
        fault_det   = st_q.en && st_q.mst && !st_q.ssig && !ss_s;
        slave_sel   = st_q.en && !st_q.mst && (st_q.ssig || !ss_s);
        wr_ctrl     = bus_wr && (bus_addr == REG_CTRL);
        wr_stat     = bus_wr && (bus_addr == REG_STAT);
        wr_data     = bus_wr && (bus_addr == REG_DATA);
        sck_rise    = sck_s && !st_q.sck_prev;
        sck_fall    = !sck_s && st_q.sck_prev;
    end

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;

        // register writes
        if (wr_ctrl) begin
            st_d.en   = bus_wdata[CTL_EN];
            st_d.mst  = bus_wdata[CTL_MST];
            st_d.ssig = bus_wdata[CTL_SSIG];
            st_d.ie   = bus_wdata[CTL_IE];
            st_d.rate = bus_wdata[CTL_RATE +: 2];
        end
        if (wr_stat) begin
            if (bus_wdata[ST_DONE]) st_d.done = 1'b0;
            if (bus_wdata[ST_WCOL]) st_d.wcol = 1'b0;
        end
        if (wr_data) begin
            if (st_q.busy) begin
                st_d.wcol = 1'b1;
            end else begin
                st_d.sr   = bus_wdata;
                st_d.bits = '0;
                st_d.sck  = 1'b0;
                st_d.busy = master_mode;
            end
        end

        // shift engine
        if (master_mode) begin
            if (st_q.busy && div_tick) begin
                if (!st_q.sck) begin
                    st_d.sck  = 1'b1;
                    st_d.samp = miso_in;
                end else begin
                    st_d.sck  = 1'b0;
                    st_d.sr   = {st_q.sr[MSB-1:0], st_q.samp};
                    st_d.bits = st_q.bits + 1'b1;
                    if (st_q.bits == CNT_W'(DATA_W - 1)) begin
                        st_d.busy  = 1'b0;
                        st_d.done  = 1'b1;
                        st_d.bits  = '0;
                        st_d.rxbuf = {st_q.sr[MSB-1:0], st_q.samp};
                    end
                end
            end
        end else if (slave_sel) begin
            st_d.sck = 1'b0;
            if (sck_rise) begin
                st_d.busy = 1'b1;
                st_d.samp = mosi_s;
            end
            if (sck_fall && st_q.busy) begin
                st_d.sr   = {st_q.sr[MSB-1:0], st_q.samp};
                st_d.bits = st_q.bits + 1'b1;
                if (st_q.bits == CNT_W'(DATA_W - 1)) begin
                    st_d.busy  = 1'b0;
                    st_d.done  = 1'b1;
                    st_d.bits  = '0;
                    st_d.rxbuf = {st_q.sr[MSB-1:0], st_q.samp};
                end
            end
        end else begin
            st_d.busy = 1'b0;
            st_d.bits = '0;
            st_d.sck  = 1'b0;
        end

        // another master took the bus
        if (fault_det) begin
            st_d.mst  = 1'b0;
            st_d.done = 1'b1;
            st_d.busy = 1'b0;
            st_d.bits = '0;
            st_d.sck  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTL_EN]       = st_q.en;
                bus_rdata[CTL_MST]      = st_q.mst;
                bus_rdata[CTL_SSIG]     = st_q.ssig;
                bus_rdata[CTL_IE]       = st_q.ie;
                bus_rdata[CTL_RATE +: 2] = st_q.rate;
            end
            REG_STAT: begin
                bus_rdata[ST_DONE] = st_q.done;
                bus_rdata[ST_WCOL] = st_q.wcol;
            end
            REG_DATA: bus_rdata = st_q.rxbuf;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq      = st_q.done && st_q.ie;
    assign sck_oe   = master_mode;
    assign mosi_oe  = master_mode;
    assign sck_out  = master_mode && st_q.sck;
    assign mosi_out = master_mode && st_q.sr[MSB];
    assign miso_oe  = slave_sel;
    assign miso_out = slave_sel && st_q.sr[MSB];

endmodule

// File: rtl/spi_node_chk.sv
module spi_node_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fault,
    input logic              mst,
    input logic              done,
    input logic              wr_data,
    input logic              busy,
    input logic              wcol,
    input logic [DATA_W-1:0] rxbuf,
    input logic              sck_out,
    input logic              sck_oe,
    input logic              miso_oe,
    input logic              tick
);

    // R4
    fault_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!mst && done));

    // R7
    collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> wcol);

    // R9
    rxbuf_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxbuf) |-> done);

    // R3
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck_out) && sck_oe && $past(sck_oe)) |-> $past(tick));

    // R11
    pin_dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_oe |-> !miso_oe);

endmodule

bind spi_node spi_node_chk #(.DATA_W(DATA_W)) i_spi_node_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fault  (fault_det),
    .mst    (st_q.mst),
    .done   (st_q.done),
    .wr_data(wr_data),
    .busy   (st_q.busy),
    .wcol   (st_q.wcol),
    .rxbuf  (st_q.rxbuf),
    .sck_out(sck_out),
    .sck_oe (sck_oe),
    .miso_oe(miso_oe),
    .tick   (div_tick)
);

// File: tb/test_spi_node.sv
module test_spi_node;
    import spi_node_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       ss_n = 1'b1;
    logic       sck_in = 1'b0;
    logic       sck_out, sck_oe;
    logic       mosi_in = 1'b0;
    logic       mosi_out, mosi_oe;
    logic       miso_in;
    logic       miso_out, miso_oe;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] slave_tx = 8'h00;
    int         fall_cnt = 0;
    int         base = 0;
    logic [7:0] miso_sh;
    logic [7:0] mon_v;
    logic [7:0] rv;

    always #5 clk = ~clk;

    spi_node i_spi_node (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ss_n(ss_n),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe)
    );

    // bench slave: presents slave_tx MSB first, advancing on falling sck_out
    always @(negedge sck_out) fall_cnt <= fall_cnt + 1;
    always_comb begin
        miso_sh = slave_tx << (fall_cnt - base);
        miso_in = ((fall_cnt - base) < 8) ? miso_sh[7] : 1'b0;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // waits for status bit 7, checks irq, then clears bit 7
    task automatic wait_done(input string req);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < 5000; i++) begin
            rd(REG_STAT, s);
            if (s[7]) break;
        end
        chk({req, " done flag"}, {7'd0, s[7]}, 8'h01);
        chk({req, " irq"}, {7'd0, irq}, 8'h01);
        wr(REG_STAT, 8'h80);
    endtask

    // scoreboard driver: a master transfer against the bench slave
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] stx, input int period);
        time t0, t1;
        logic [7:0] r;
        slave_tx = stx;
        base     = fall_cnt;
        exp_q.push_back(tx);
        wr(REG_DATA, tx);
        @(posedge sck_out);
        t0 = $time;
        @(posedge sck_out);
        t1 = $time;
        chk_int("R3 sck period in clocks", int'((t1 - t0) / 10), period);
        wait_done("R2");
        rd(REG_DATA, r);
        chk("R2 byte captured from miso", r, stx);
    endtask

    // bench master for slave tests: 4 clocks low, 4 clocks high per bit
    task automatic bench_master(input logic [7:0] tx, output logic [7:0] rx);
        logic [7:0] t;
        t  = tx;
        rx = 8'h00;
        for (int b = 0; b < 8; b++) begin
            mosi_in = t[7];
            t = t << 1;
            repeat (4) @(negedge clk);
            rx = {rx[6:0], miso_out};
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    // scoreboard monitor: bytes seen on mosi_out against the queue
    initial begin
        forever begin
            mon_v = 8'h00;
            for (int b = 0; b < 8; b++) begin
                @(posedge sck_out);
                mon_v = {mon_v[6:0], mosi_out};
            end
            if (exp_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R2 unexpected byte on mosi: actual=%0h expected=none", mon_v);
            end else begin
                chk("R2/R7 byte shifted out on mosi", mon_v, exp_q.pop_front());
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(REG_CTRL, rv); chk("R1 control after reset", rv, 8'h00);
        rd(REG_STAT, rv); chk("R1 status after reset", rv, 8'h00);
        rd(REG_DATA, rv); chk("R1 data after reset", rv, 8'h00);
        chk("R1 pin enables and irq", {4'd0, sck_oe, mosi_oe, miso_oe, irq}, 8'h00);

        // R2/R3 master transfers at all four rates
        wr(REG_CTRL, 8'h0B);
        repeat (2) @(negedge clk);
        chk("R11 master pin enables", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h06);
        master_xfer(8'hA5, 8'h3C, 4);
        wr(REG_CTRL, 8'h1B);
        master_xfer(8'h5A, 8'hC3, 16);
        wr(REG_CTRL, 8'h2B);
        master_xfer(8'h81, 8'h7E, 64);
        wr(REG_CTRL, 8'h3B);
        master_xfer(8'h01, 8'h80, 128);

        // R7 master write collision
        wr(REG_CTRL, 8'h1B);
        slave_tx = 8'h99;
        base     = fall_cnt;
        exp_q.push_back(8'h42);
        wr(REG_DATA, 8'h42);
        repeat (20) @(negedge clk);
        wr(REG_DATA, 8'hE7);
        wait_done("R7");
        rd(REG_STAT, rv); chk("R7 collision flag in master", rv, 8'h40);
        rd(REG_DATA, rv); chk("R7 transfer unaffected by collided write", rv, 8'h99);
        // R8 write-one-to-clear
        wr(REG_STAT, 8'h00);
        rd(REG_STAT, rv); chk("R8 writing zero keeps collision flag", rv, 8'h40);
        wr(REG_STAT, 8'h40);
        rd(REG_STAT, rv); chk("R8 collision flag cleared", rv, 8'h00);

        // R4 mode fault
        wr(REG_CTRL, 8'h0B);
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        rd(REG_CTRL, rv); chk("R4 master bit cleared", rv, 8'h09);
        rd(REG_STAT, rv); chk("R4 done flag set by fault", rv, 8'h80);
        chk("R4 pin directions after fault", {4'd0, sck_oe, mosi_oe, miso_oe, irq}, 8'h03);
        // R5 stays slave
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        rd(REG_CTRL, rv); chk("R5 remains slave after release", rv, 8'h09);
        chk("R5 no clock drive after release", {7'd0, sck_oe}, 8'h00);
        wr(REG_STAT, 8'h80);
        rd(REG_STAT, rv); chk("R8 done flag cleared", rv, 8'h00);
        chk("R8 irq follows done", {7'd0, irq}, 8'h00);
        wr(REG_CTRL, 8'h0B);
        repeat (2) @(negedge clk);
        chk("R5 master restored by software", {7'd0, sck_oe}, 8'h01);

        // R6 slave select ignored
        wr(REG_CTRL, 8'h0F);
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        rd(REG_CTRL, rv); chk("R6 master bit kept with ss low", rv, 8'h0F);
        rd(REG_STAT, rv); chk("R6 no fault flagged", rv, 8'h00);
        master_xfer(8'h6D, 8'hB2, 4);
        ss_n = 1'b1;

        // R10 slave transfer
        wr(REG_CTRL, 8'h09);
        repeat (4) @(negedge clk);
        chk("R10 miso undriven when deselected", {7'd0, miso_oe}, 8'h00);
        wr(REG_DATA, 8'h96);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10/R11 slave pin enables", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h01);
        bench_master(8'h5A, r);
        chk("R10 slave byte on miso", r, 8'h96);
        rd(REG_STAT, rv); chk("R10 slave done flag", rv, 8'h80);
        rd(REG_DATA, rv); chk("R10 slave received byte", rv, 8'h5A);
        wr(REG_STAT, 8'h80);

        // R9 overrun: two bytes, no read between
        bench_master(8'h11, r);
        bench_master(8'h22, r);
        chk("R10 slave shifts out last received byte", r, 8'h11);
        rd(REG_DATA, rv); chk("R9 unread byte overwritten", rv, 8'h22);
        wr(REG_STAT, 8'h80);

        // R7 slave write collision
        fork
            bench_master(8'h3C, r);
            begin
                repeat (20) @(negedge clk);
                wr(REG_DATA, 8'hEE);
            end
        join
        chk("R7 collided byte not sent by slave", r, 8'h22);
        rd(REG_STAT, rv); chk("R7 collision flag in slave", rv, 8'hC0);
        rd(REG_DATA, rv); chk("R7 slave reception intact", rv, 8'h3C);
        wr(REG_STAT, 8'hC0);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 miso released when ss high", {7'd0, miso_oe}, 8'h00);

        chk_int("R2 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule